// File: doc/BRIEF.md
# I2C Target with 10-bit Addressing and General Call

This block is the target side of an I2C bus. It samples the bus clock and data lines through synchronizers and detects START, repeated START and STOP. It decodes the first byte after a START against either a 7-bit or a 10-bit own address, and acknowledges a match. It then moves bytes between the bus and a simple local byte interface. Received bytes appear as one-cycle pulses. Bytes to be sent are requested from the local side, and SCL is held low until the local side supplies one.

In 10-bit mode the block keeps a record of a completed two-byte write match. After a repeated START, that record lets the one-byte read header select the block without a second address byte. When enabled, the general call address is acknowledged and the bytes that follow it are delivered with a flag. Both bus lines are open drain: the block only ever asks for a line to be pulled low.

Top module: `i2c_target`

## Requirements
- R1: After reset, sda_oe_o, scl_oe_o, tx_req_o and rx_valid_o are all 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START returns to address decoding. After a STOP no byte is acknowledged until a new START.
- R3: With addr10_en_i=0, a first byte whose bits [7:1] equal own_addr_i[6:0] is acknowledged, and its bit 0 selects read (1) or write (0). Any other first byte is not acknowledged, and nothing after it is acknowledged until the next START.
- R4: In a selected write, every data byte is taken MSB first and acknowledged. It appears on rx_data_o with a one-cycle rx_valid_o pulse.
- R5: In a selected read, tx_req_o is raised and scl_oe_o holds SCL low until tx_valid_i is seen with tx_req_o. SCL is released two cycles after that cycle, and the byte is sent MSB first.
- R6: A master NACK after a read byte ends the read. SDA stays released and tx_req_o stays 0 until the next START.
- R7: With addr10_en_i=1, the header 11110 followed by own_addr_i[9:8] and a 0 direction bit is acknowledged. The next byte must equal own_addr_i[7:0] to be acknowledged; otherwise it is not acknowledged.
- R8: In 10-bit mode, a header with direction bit 1 is acknowledged as a read only when the last completed address phase since the last STOP was a full 10-bit write match of this block.
- R9: With gc_en_i=1, a first byte of 0x00 is acknowledged and the following bytes are delivered with rx_gc_o=1. With gc_en_i=0 it is not acknowledged and nothing is delivered.
- R10: The block only pulls the lines low, and sda_oe_o changes only while SCL is low. While tx_req_o is high SDA is released.
- R11: A START or STOP inside a byte discards that partial byte (no rx_valid_o) and drops the current selection.
- R12: With addr10_en_i=1, 7-bit address matches are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 10 | Own address; low 7 bits used in 7-bit mode |
| addr10_en_i | input | 1 | Selects 10-bit addressing |
| gc_en_i | input | 1 | Enables general call response |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle pulse per received byte |
| rx_gc_o | output | 1 | Received byte belongs to a general call |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_req_o | output | 1 | Block needs a byte to send |

## Verification
The properties rely on the following conditions:
- The system clock runs at least 8 times faster than SCL, so each SCL phase lasts several cycles after synchronization.
- The master drives SDA only while SCL is low, except when it forms a START or STOP.
- The master waits for SCL to actually go high, which lets clock stretching work.
- The configuration inputs stay fixed during a transaction.

The bench master keeps SCL at each level for 10 clock cycles and samples the bus line rather than its own drive. It changes own_addr_i, addr10_en_i and gc_en_i only after a STOP. It returns SCL low before any bit that follows a STOP, so no false condition appears.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam logic [4:0] TEN_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_LOAD, ST_SETUP, ST_SEND, ST_MACK
  } st_e;

  typedef enum logic [1:0] {PH_ADR1, PH_ADR2, PH_WR, PH_RD} ph_e;

  typedef struct packed {
    logic ack;
    ph_e  nxt;
    logic gc;
    logic ten_set;
    logic ten_clr;
  } dec_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '1;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '1;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/i2ct_addr_dec.sv
module i2ct_addr_dec
  import i2ct_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  ph_e               phase_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr10_en_i,
  input  logic              gc_en_i,
  input  logic              ten_full_i,
  output dec_t              dec_o
);
  logic gc_hit, hdr10, hit7;

  always_comb begin
    gc_hit = gc_en_i && (byte_i == '0);
    hdr10  = addr10_en_i && (byte_i[7:3] == TEN_TAG)
             && (byte_i[2:1] == own_addr_i[ADDR_W-1 -: 2]);
    hit7   = !addr10_en_i && (byte_i[7:1] == own_addr_i[6:0]);
    dec_o     = '0;
    dec_o.nxt = PH_ADR1;
    case (phase_i)
      PH_ADR1: begin
        if (gc_hit) begin
          dec_o.ack = 1'b1; dec_o.nxt = PH_WR; dec_o.gc = 1'b1; dec_o.ten_clr = 1'b1;
        end else if (hdr10 && !byte_i[0]) begin
          dec_o.ack = 1'b1; dec_o.nxt = PH_ADR2; dec_o.ten_clr = 1'b1;
        end else if (hdr10 && ten_full_i) begin
          dec_o.ack = 1'b1; dec_o.nxt = PH_RD;   // read after full 10-bit write match
        end else if (hit7) begin
          dec_o.ack = 1'b1; dec_o.nxt = byte_i[0] ? PH_RD : PH_WR; dec_o.ten_clr = 1'b1;
        end else begin
          dec_o.ten_clr = 1'b1;
        end
      end
      PH_ADR2: begin
        if (byte_i == own_addr_i[7:0]) begin
          dec_o.ack = 1'b1; dec_o.nxt = PH_WR; dec_o.ten_set = 1'b1;
        end else begin
          dec_o.ten_clr = 1'b1;
        end
      end
      default: begin
        dec_o.ack = 1'b1;
        dec_o.nxt = phase_i;
      end
    endcase
  end
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr10_en_i,
  input  logic              gc_en_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_gc_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_req_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic start, stop, rise, fall;
  st_e  st;
  ph_e  ph;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, byte_in;
  logic ack_drv, slot, mack, is_gc, ten_full;
  dec_t dec;

  i2ct_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  i2ct_cond u_cond (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  assign byte_in = {shreg[BYTE_W-2:0], sda_s};

  i2ct_addr_dec u_dec (
    .byte_i(byte_in), .phase_i(ph), .own_addr_i, .addr10_en_i,
    .gc_en_i, .ten_full_i(ten_full), .dec_o(dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE;  ph <= PH_ADR1;  bit_cnt <= '0;  shreg <= '0;
      ack_drv <= 1'b0;  slot <= 1'b0;  mack <= 1'b0;
      is_gc <= 1'b0;  ten_full <= 1'b0;
      rx_valid_o <= 1'b0;  rx_data_o <= '0;  rx_gc_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (stop) begin
        st <= ST_IDLE;  ph <= PH_ADR1;  bit_cnt <= '0;
        ack_drv <= 1'b0;  is_gc <= 1'b0;  ten_full <= 1'b0;
      end else if (start) begin
        // ten_full survives a repeated start
        st <= ST_RECV;  ph <= PH_ADR1;  bit_cnt <= '0;
        ack_drv <= 1'b0;  is_gc <= 1'b0;
      end else begin
        case (st)
          ST_RECV: if (rise) begin
            shreg   <= byte_in;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (dec.ack) begin
                ph   <= dec.nxt;
                st   <= ST_ACK;
                slot <= 1'b0;
                if (ph == PH_WR) begin
                  rx_valid_o <= 1'b1;
                  rx_data_o  <= byte_in;
                  rx_gc_o    <= is_gc;
                end
                if (ph == PH_ADR1) is_gc <= dec.gc;
              end else begin
                st <= ST_IDLE;
              end
              if (dec.ten_set)      ten_full <= 1'b1;
              else if (dec.ten_clr) ten_full <= 1'b0;
            end
          end
          ST_ACK: if (fall) begin
            if (!slot) begin
              ack_drv <= 1'b1;
              slot    <= 1'b1;
            end else begin
              ack_drv <= 1'b0;
              st      <= (ph == PH_RD) ? ST_LOAD : ST_RECV;
            end
          end
          ST_LOAD: if (tx_valid_i) begin
            shreg <= tx_data_i;
            st    <= ST_SETUP;
          end
          ST_SETUP: st <= ST_SEND;  // data settles before SCL is released
          ST_SEND: if (fall) begin
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              mack    <= 1'b0;
              st      <= ST_MACK;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= {shreg[BYTE_W-2:0], 1'b1};
            end
          end
          ST_MACK: begin
            if (rise)      mack <= ~sda_s;
            else if (fall) st   <= mack ? ST_LOAD : ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_req_o = (st == ST_LOAD);
  assign scl_oe_o = (st == ST_LOAD) || (st == ST_SETUP);
  assign sda_oe_o = ack_drv | (((st == ST_SETUP) || (st == ST_SEND)) & ~shreg[BYTE_W-1]);
endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic scl_oe_o,
  input logic tx_req_o,
  input logic tx_valid_i,
  input logic rx_valid_o,
  input logic rx_gc_o,
  input logic gc_en_i
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R10
  AST_REQ_SDA_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> !sda_oe_o); // R10
  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && !tx_valid_i |=> tx_req_o && scl_oe_o); // R5
  AST_STRETCH_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && tx_valid_i |=> !tx_req_o ##1 !scl_oe_o); // R5
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R4
  AST_RX_NOT_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !tx_req_o); // R4
  AST_GC_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && rx_gc_o |-> gc_en_i); // R9
endmodule

bind i2c_target i2c_target_chk u_chk (.*);

// File: tb/i2c_target_tb.sv
module i2c_target_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic [9:0] own_addr = 10'h052;
  logic addr10_en = 1'b0, gc_en = 1'b0;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, rx_gc, tx_valid = 1'b0, tx_req;

  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_target dut_i (
    .clk_i(clk), .rst_ni, .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr),
    .addr10_en_i(addr10_en), .gc_en_i(gc_en), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_gc_o(rx_gc), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_req_o(tx_req)
  );

  int n_tests = 0, n_fail = 0;
  logic [8:0] rx_log [16];
  int rx_n = 0;
  logic [7:0] tx_q [8];
  int tx_rd = 0, tx_dly = 0, stretch_bad = 0, sda_viol = 0;
  logic sda_oe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // receive log and SDA-change monitor
  always @(negedge clk) begin
    if (rst_ni && rx_valid) begin
      if (rx_n < 16) rx_log[rx_n] = {rx_gc, rx_data};
      rx_n++;
    end
    if (rst_ni && (sda_oe !== sda_oe_prev) && scl_bus) sda_viol++;
    sda_oe_prev = sda_oe;
  end

  // local transmit side with programmable delay
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && tx_req) begin
        repeat (tx_dly) begin
          @(negedge clk);
          if (!scl_oe || scl_bus) stretch_bad++;
        end
        tx_data  = tx_q[tx_rd % 8];
        tx_valid = 1'b1;
        tx_rd++;
        @(negedge clk);
        tx_valid = 1'b0;
        @(negedge clk);
        if (scl_oe) stretch_bad++;
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic scl_hi(); scl_m = 1'b1; while (!scl_bus) @(negedge clk); endtask
  task automatic m_start(); sda_m = 1'b1; wq(); scl_hi(); wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq(); endtask
  task automatic m_stop(); sda_m = 1'b0; wq(); scl_hi(); wq(); sda_m = 1'b1; wq(); endtask
  task automatic m_wbit(input bit b); sda_m = b; wq(); scl_hi(); wq(); scl_m = 1'b0; wq(); endtask
  task automatic m_rbit(output bit b); sda_m = 1'b1; wq(); scl_hi(); wq(); b = sda_bus; scl_m = 1'b0; wq(); endtask
  task automatic m_wbyte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    ack = !b;
  endtask
  task automatic m_rbyte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
    m_wbit(!ack);
  endtask

  task automatic t_reset();
    chk(sda_oe == 0 && scl_oe == 0, "R1 lines released", {sda_oe, scl_oe}, 0);
    chk(tx_req == 0 && rx_valid == 0, "R1 no request", {tx_req, rx_valid}, 0);
  endtask

  task automatic t_write7();
    bit a; int r0 = rx_n;
    m_start(); m_wbyte(8'hA4, a); chk(a, "R3 addr ack", a, 1);
    m_wbyte(8'hA5, a); chk(a, "R4 data ack", a, 1);
    m_wbyte(8'h3C, a); m_stop();
    chk(rx_n - r0 == 2, "R4 byte count", rx_n - r0, 2);
    chk(rx_log[r0] == 9'h0A5, "R4 byte0", rx_log[r0], 9'h0A5);
    chk(rx_log[r0+1] == 9'h03C, "R4 byte1", rx_log[r0+1], 9'h03C);
  endtask

  task automatic t_miss7();
    bit a; int r0 = rx_n;
    m_start(); m_wbyte(8'hA6, a); chk(!a, "R3 wrong addr nack", a, 0);
    m_wbyte(8'hFF, a); chk(!a, "R3 later byte ignored", a, 0);
    m_stop();
    chk(rx_n == r0, "R3 nothing delivered", rx_n - r0, 0);
  endtask

  task automatic t_read7();
    bit a; logic [7:0] d; int t0 = tx_rd, sb = stretch_bad;
    tx_q[t0 % 8] = 8'hC3; tx_q[(t0+1) % 8] = 8'h5A; tx_dly = 25;
    m_start(); m_wbyte(8'hA5, a); chk(a, "R3 read addr ack", a, 1);
    m_rbyte(d, 1'b1); chk(d == 8'hC3, "R5 read byte0", d, 8'hC3);
    m_rbyte(d, 1'b0); chk(d == 8'h5A, "R5 read byte1", d, 8'h5A);
    repeat (40) @(negedge clk);
    chk(!tx_req && !sda_oe, "R6 idle after nack", {tx_req, sda_oe}, 0);
    m_rbyte(d, 1'b0); chk(d == 8'hFF, "R6 sda released", d, 8'hFF);
    m_stop();
    chk(stretch_bad == sb, "R5 stretch window", stretch_bad - sb, 0);
    chk(tx_rd - t0 == 2, "R6 request count", tx_rd - t0, 2);
    tx_dly = 0;
  endtask

  task automatic t_rep_start7();
    bit a; logic [7:0] d; int r0 = rx_n;
    tx_q[tx_rd % 8] = 8'h81;
    m_start(); m_wbyte(8'hA4, a); m_wbyte(8'h11, a);
    m_start(); m_wbyte(8'hA5, a); chk(a, "R2 rep start addr ack", a, 1);
    m_rbyte(d, 1'b0); chk(d == 8'h81, "R2 read after rep start", d, 8'h81);
    m_stop();
    chk(rx_n - r0 == 1 && rx_log[r0] == 9'h011, "R2 write before rep start", rx_log[r0], 9'h011);
    scl_m = 1'b0; wq();
    m_wbyte(8'hA4, a); chk(!a, "R2 no ack after stop", a, 0);
    m_stop();
  endtask

  task automatic t_gc();
    bit a; int r0;
    gc_en = 1'b1; r0 = rx_n;
    m_start(); m_wbyte(8'h00, a); chk(a, "R9 gc ack", a, 1);
    m_wbyte(8'h06, a); m_stop();
    chk(rx_n - r0 == 1 && rx_log[r0] == 9'h106, "R9 gc command", rx_log[r0], 9'h106);
    gc_en = 1'b0; r0 = rx_n;
    m_start(); m_wbyte(8'h00, a); chk(!a, "R9 gc disabled nack", a, 0);
    m_wbyte(8'h06, a); m_stop();
    chk(rx_n == r0, "R9 gc disabled no data", rx_n - r0, 0);
  endtask

  task automatic t_ten();
    bit a; logic [7:0] d; int r0;
    addr10_en = 1'b1; own_addr = 10'h2B7; r0 = rx_n;
    m_start(); m_wbyte(8'hF4, a); chk(a, "R7 header ack", a, 1);
    m_wbyte(8'hB7, a); chk(a, "R7 low byte ack", a, 1);
    m_wbyte(8'h5E, a); m_stop();
    chk(rx_n - r0 == 1 && rx_log[r0] == 9'h05E, "R7 10-bit data", rx_log[r0], 9'h05E);
    m_start(); m_wbyte(8'hF4, a); m_wbyte(8'hB6, a);
    chk(!a, "R7 wrong low byte nack", a, 0);
    m_stop();
    tx_q[tx_rd % 8] = 8'h99;
    m_start(); m_wbyte(8'hF4, a); m_wbyte(8'hB7, a);
    m_start(); m_wbyte(8'hF5, a); chk(a, "R8 read header ack", a, 1);
    m_rbyte(d, 1'b0); chk(d == 8'h99, "R8 10-bit read", d, 8'h99);
    m_stop();
    m_start(); m_wbyte(8'hF5, a); chk(!a, "R8 cold read header nack", a, 0);
    m_stop();
    m_start(); m_wbyte(8'h6E, a); chk(!a, "R12 7-bit ignored", a, 0);
    m_stop();
    addr10_en = 1'b0; own_addr = 10'h052;
  endtask

  task automatic t_abort();
    bit a; int r0 = rx_n;
    m_start(); m_wbyte(8'hA4, a);
    for (int i = 0; i < 5; i++) m_wbit(1'b0);
    m_stop();
    chk(rx_n == r0, "R11 stop mid-byte", rx_n - r0, 0);
    m_start(); m_wbyte(8'hA4, a);
    for (int i = 0; i < 4; i++) m_wbit(1'b1);
    m_start(); m_wbyte(8'h77, a);
    chk(!a, "R11 selection dropped", a, 0);
    m_stop();
    chk(rx_n == r0, "R11 start mid-byte", rx_n - r0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    t_write7();
    t_miss7();
    t_read7();
    t_rep_start7();
    t_gc();
    t_ten();
    t_abort();
    chk(sda_viol == 0, "R10 sda moved with scl high", sda_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule